// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Controller

This block keeps a two-bit pending/queued state for each of `N` interrupt sources and merges repeated triggers, so that a source is never waiting in the downstream queue more than once. Edge-type sources are triggered by single-cycle pulses. Level-type sources are triggered when their level input rises. Every accepted event turns into a notification that carries the source number. The notification goes to a router over a valid/ready handshake.

Software reaches each source through a page of `2^PAGE_SHIFT` bytes in a flat load/store space. The source number sits in the address bits above the page. Special offsets inside the page do the following:

- read the state,
- perform end-of-interrupt (EOI),
- force the state to any of its four values.

Each such load returns the state as it was before the access, and the update happens in the same cycle. An odd `PAGE_SHIFT` splits the page into two halves: the lower half is the trigger half and the upper half is the management half. An even `PAGE_SHIFT` keeps a single page that serves both purposes.

Back-pressure rules on the notification output:

- While `ntf_valid` is high and `ntf_ready` is low, `ntf_src` holds still.
- Events that arrive during a stall are not lost. They stay as one request bit per source, and repeated requests for the same source merge into that bit.
- When several sources are waiting, the lowest-numbered source is offered first.

The load/store port has no back-pressure. One access may be presented every cycle.

Top module: `ipq_src_ctrl`

## Requirements
- R1: State encoding is P = bit 1 and Q = bit 0: 00 is idle, 10 is pending, 11 is pending with a repeat seen, and 01 is off. After reset every source is 00, `ntf_valid` is 0 and `rsp_valid` is 0.
- R2: A trigger acts on the state as follows:
  - 00 becomes 10 and requests one notification.
  - 10 becomes 11 with no notification.
  - 11 stays 11.
  - 01 stays 01 and requests nothing.
- R3: EOI acts on the state as follows:
  - 10 becomes 00.
  - 11 becomes 10 and requests a new notification.
  - 00 and 01 are left unchanged.
  
  A load at management offset 0x000 performs EOI.
- R4: Every load produces `rsp_valid` for exactly one cycle, in the cycle after the access. `rsp_pq` carries the addressed source's state from before the access. A load at management offset 0x800 changes nothing.
- R5: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively, which is address bits [9:8].
- R6: A store at management offset 0x400 performs EOI only while `store_eoi_en` is 1. While `store_eoi_en` is 0 the store has no effect.
- R7: Address layout depends on `PAGE_SHIFT`.
  - Odd `PAGE_SHIFT`: address bit `PAGE_SHIFT-1` = 1 selects the management half. A store to the lower half triggers the source, and a load from the lower half returns the state unchanged. Stores in the management half other than 0x400 are ignored.
  - Even `PAGE_SHIFT`: any store other than 0x400 triggers the source.
  - In both layouts, an access with any nonzero offset bit outside bits [11:8] (and outside the half-select bit) acts as a plain read for a load and is ignored for a store.
- R8: Sources set in `LEVEL_MASK` are level sources. For a level source:
  - `trig_pulse` is ignored.
  - The asserted bit follows `lvl_in`, and a 0-to-1 change of `lvl_in` is a trigger.
  - EOI from 10 while the input is still asserted leaves 10 and requests a new notification.
- R9: The notification output behaves as follows:
  - `ntf_valid` and `ntf_src` hold until `ntf_ready` is sampled high.
  - Waiting sources are offered lowest number first.
  - A trigger from 00 sampled at one clock edge raises `ntf_valid` after the next edge when the output is free.
- R10: When an access and a hardware trigger hit the same source in one cycle, the access is applied first and the trigger then acts on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pulse | input | N | Single-cycle trigger per edge source |
| lvl_in | input | N | Level input per level source |
| store_eoi_en | input | 1 | Permits EOI by store at offset 0x400 |
| acc_valid | input | 1 | Load/store access present this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | SRC_W+PAGE_SHIFT | Source number above page offset |
| rsp_valid | output | 1 | Load response present |
| rsp_pq | output | 2 | State before the load (P at bit 1) |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Router accepts notification |
| ntf_src | output | SRC_W | Source number of the notification |

## Verification
- **Load responses:** a load sampled at one rising edge has its old-state response visible right after that same edge. Every directed load is therefore checked half a cycle after the edge that took it.
- **Notifications:** a trigger takes two edges to reach `ntf_valid`, one into the request bit and one into the output stage. The bench checks for absence after the first edge and presence after the second.
- **Cycle model:** a bench model advances one step per edge from the requirements alone. At every falling edge it is compared with `rsp_valid`, `rsp_pq`, `ntf_valid` and `ntf_src`, so stalls and merged requests are checked in the exact cycle they take effect.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET
  } pq_op_e;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  localparam logic [3:0] CODE_LOAD_EOI  = 4'h0;
  localparam logic [3:0] CODE_STORE_EOI = 4'h4;
  localparam logic [3:0] CODE_GET       = 4'h8;
  localparam logic [1:0] CODE_SET_HI    = 2'b11;

  typedef struct packed {
    logic [1:0] pq;
    logic       fire;
  } pq_step_t;

  // Trigger: idle -> pending with a notification; pending -> queued; others hold.
  function automatic pq_step_t pq_trigger(input logic [1:0] s);
    pq_step_t r;
    r.pq   = s;
    r.fire = 1'b0;
    if (s == PQ_IDLE) begin
      r.pq   = PQ_PEND;
      r.fire = 1'b1;
    end else if (s == PQ_PEND) begin
      r.pq = PQ_QUEUED;
    end
    return r;
  endfunction

  // End of interrupt; still_high re-fires a level source that is still asserted.
  function automatic pq_step_t pq_eoi(input logic [1:0] s, input logic still_high);
    pq_step_t r;
    r.pq   = s;
    r.fire = 1'b0;
    if (s == PQ_QUEUED) begin
      r.pq   = PQ_PEND;
      r.fire = 1'b1;
    end else if (s == PQ_PEND) begin
      r.pq   = still_high ? PQ_PEND : PQ_IDLE;
      r.fire = still_high;
    end
    return r;
  endfunction

endpackage

// File: rtl/ipq_access_decode.sv
module ipq_access_decode
  import ipq_pkg::*;
#(
  parameter int N          = 8,
  parameter int PAGE_SHIFT = 13,
  localparam int SRC_W     = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W    = SRC_W + PAGE_SHIFT
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              store_eoi_en,
  output pq_op_e            op,
  output logic [1:0]        set_val,
  output logic [N-1:0]      hit
);

  localparam bit TWO_PAGE = (PAGE_SHIFT % 2) == 1;
  localparam int SUB_W    = TWO_PAGE ? PAGE_SHIFT - 1 : PAGE_SHIFT;

  logic [SRC_W-1:0] idx;
  logic [3:0]       code;
  logic             mgmt_half;
  logic             misaligned;

  assign idx  = acc_addr[ADDR_W-1:PAGE_SHIFT];
  assign code = acc_addr[11:8];

  generate
    if (TWO_PAGE) begin : g_two
      assign mgmt_half = acc_addr[PAGE_SHIFT-1];
    end else begin : g_one
      assign mgmt_half = 1'b1;
    end
    if (SUB_W > 12) begin : g_wide
      assign misaligned = |{acc_addr[SUB_W-1:12], acc_addr[7:0]};
    end else begin : g_narrow
      assign misaligned = |acc_addr[7:0];
    end
    for (genvar i = 0; i < N; i++) begin : g_hit
      assign hit[i] = acc_valid && (idx == SRC_W'(i));
    end
  endgenerate

  always_comb begin
    op      = OP_NONE;
    set_val = code[1:0];
    if (acc_valid) begin
      if (misaligned) begin
        op = acc_write ? OP_NONE : OP_GET;
      end else if (!mgmt_half) begin
        op = acc_write ? OP_TRIG : OP_GET;
      end else if (acc_write) begin
        if (code == CODE_STORE_EOI) begin
          op = store_eoi_en ? OP_EOI : OP_NONE;
        end else begin
          op = TWO_PAGE ? OP_NONE : OP_TRIG;
        end
      end else if (code == CODE_LOAD_EOI) begin
        op = OP_EOI;
      end else if (code == CODE_GET) begin
        op = OP_GET;
      end else if (code[3:2] == CODE_SET_HI) begin
        op = OP_SET;
      end else begin
        op = OP_GET;
      end
    end
  end

endmodule

// File: rtl/ipq_cell.sv
module ipq_cell
  import ipq_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  pq_op_e     op,
  input  logic [1:0] set_val,
  input  logic       hw_trig,
  input  logic       lvl_in,
  output logic [1:0] pq,
  output logic       fire
);

  logic [1:0] pq_q;
  logic       asrt_q;
  logic [1:0] pq_d;
  logic       evt;
  pq_step_t   a_step;
  pq_step_t   t_step;
  logic [1:0] after_acc;
  logic       fire_acc;

  assign evt = IS_LEVEL ? (lvl_in & ~asrt_q) : hw_trig;

  always_comb begin
    after_acc = pq_q;
    fire_acc  = 1'b0;
    a_step    = '0;
    if (hit) begin
      unique case (op)
        OP_TRIG: begin
          a_step    = pq_trigger(pq_q);
          after_acc = a_step.pq;
          fire_acc  = a_step.fire;
        end
        OP_EOI: begin
          a_step    = pq_eoi(pq_q, IS_LEVEL && asrt_q);
          after_acc = a_step.pq;
          fire_acc  = a_step.fire;
        end
        OP_SET:  after_acc = set_val;
        default: after_acc = pq_q;
      endcase
    end
    t_step = pq_trigger(after_acc);
    if (evt) begin
      pq_d = t_step.pq;
      fire = fire_acc | t_step.fire;
    end else begin
      pq_d = after_acc;
      fire = fire_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q   <= PQ_IDLE;
      asrt_q <= 1'b0;
    end else begin
      pq_q   <= pq_d;
      asrt_q <= IS_LEVEL ? lvl_in : 1'b0;
    end
  end

  assign pq = pq_q;

endmodule

// File: rtl/ipq_notify.sv
module ipq_notify #(
  parameter int N     = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     fire,
  output logic             ntf_valid,
  input  logic             ntf_ready,
  output logic [SRC_W-1:0] ntf_src
);

  logic [N-1:0]     nreq_q;
  logic [N-1:0]     clr;
  logic             out_v_q;
  logic [SRC_W-1:0] out_s_q;
  logic [SRC_W-1:0] pick;
  logic             any;
  logic             free;

  assign free = !out_v_q || ntf_ready;
  assign any  = |nreq_q;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (nreq_q[i]) pick = SRC_W'(i);
    end
  end

  assign clr = (free && any) ? (N'(1) << pick) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nreq_q  <= '0;
      out_v_q <= 1'b0;
      out_s_q <= '0;
    end else begin
      nreq_q <= (nreq_q & ~clr) | fire;
      if (free) begin
        out_v_q <= any;
        out_s_q <= pick;
      end
    end
  end

  assign ntf_valid = out_v_q;
  assign ntf_src   = out_s_q;

endmodule

// File: rtl/ipq_src_ctrl.sv
module ipq_src_ctrl
  import ipq_pkg::*;
#(
  parameter int           N          = 8,
  parameter int           PAGE_SHIFT = 13,
  parameter logic [N-1:0] LEVEL_MASK = 'hC0,
  localparam int SRC_W  = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W = SRC_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      trig_pulse,
  input  logic [N-1:0]      lvl_in,
  input  logic              store_eoi_en,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_pq,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [SRC_W-1:0]  ntf_src
);

  pq_op_e          op;
  logic [1:0]      set_val;
  logic [N-1:0]    hit;
  logic [N-1:0]    fire;
  logic [N-1:0][1:0] pq_vec;
  logic [1:0]      old_pq;
  logic            rsp_v_q;
  logic [1:0]      rsp_pq_q;

  ipq_access_decode #(.N(N), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .store_eoi_en(store_eoi_en),
    .op          (op),
    .set_val     (set_val),
    .hit         (hit)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      ipq_cell #(.IS_LEVEL(LEVEL_MASK[i])) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit[i]),
        .op     (op),
        .set_val(set_val),
        .hw_trig(trig_pulse[i]),
        .lvl_in (lvl_in[i]),
        .pq     (pq_vec[i]),
        .fire   (fire[i])
      );
    end
  endgenerate

  ipq_notify #(.N(N), .SRC_W(SRC_W)) u_ntf (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .ntf_valid(ntf_valid),
    .ntf_ready(ntf_ready),
    .ntf_src  (ntf_src)
  );

  always_comb begin
    old_pq = PQ_IDLE;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) old_pq = pq_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q  <= 1'b0;
      rsp_pq_q <= PQ_IDLE;
    end else begin
      rsp_v_q <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rsp_pq_q <= old_pq;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_pq    = rsp_pq_q;

endmodule

// File: rtl/ipq_src_ctrl_chk.sv
module ipq_src_ctrl_chk #(
  parameter int N          = 8,
  parameter int PAGE_SHIFT = 13,
  localparam int SRC_W     = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W    = SRC_W + PAGE_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              rsp_valid,
  input logic [1:0]        rsp_pq,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic [SRC_W-1:0]  ntf_src,
  input logic [N-1:0][1:0] pq_vec
);

  logic [SRC_W-1:0] idx;
  logic [1:0]       exp_old;
  logic             is_load;

  assign idx     = acc_addr[ADDR_W-1:PAGE_SHIFT];
  assign is_load = acc_valid && !acc_write;

  always_comb begin
    exp_old = 2'b00;
    for (int i = 0; i < N; i++) begin
      if (idx == SRC_W'(i)) exp_old = pq_vec[i];
    end
  end

  // R9: offered notification holds while stalled
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_src)));

  // R4: exactly one response cycle per load
  a_r4_rsp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> rsp_valid);
  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !is_load |=> !rsp_valid);
  a_r4_rsp_old_state: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> (rsp_pq == $past(exp_old)));

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      logic touched;
      assign touched = acc_valid && (idx == SRC_W'(i));
      // R2: hardware triggers never leave the off state
      a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_vec[i] == 2'b01 && !touched) |=> (pq_vec[i] == 2'b01));
      // R2: hardware triggers never leave the queued state
      a_r2_queued_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_vec[i] == 2'b11 && !touched) |=> (pq_vec[i] == 2'b11));
      // R2: without an access, idle only moves to pending
      a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_vec[i] == 2'b00 && !touched) |=> (pq_vec[i] == 2'b00 || pq_vec[i] == 2'b10));
    end
  endgenerate

endmodule

bind ipq_src_ctrl ipq_src_ctrl_chk #(.N(N), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_write(acc_write),
  .acc_addr (acc_addr),
  .rsp_valid(rsp_valid),
  .rsp_pq   (rsp_pq),
  .ntf_valid(ntf_valid),
  .ntf_ready(ntf_ready),
  .ntf_src  (ntf_src),
  .pq_vec   (pq_vec)
);

// File: tb/sim_ipq_src_ctrl.sv
`timescale 1ns/1ps
module sim_ipq_src_ctrl;

  localparam int N  = 8;
  localparam int SH = 13;
  localparam logic [7:0] LM = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] trig = '0;
  logic [7:0] lvl = '0;
  logic seoi = 1'b1;
  logic av = 1'b0, aw = 1'b0;
  logic [15:0] aa = '0;
  logic nrdy = 1'b0;
  logic rv, nv;
  logic [1:0] rpq;
  logic [2:0] ns;

  logic b_av = 1'b0, b_aw = 1'b0;
  logic [14:0] b_aa = '0;
  logic b_rv, b_nv;
  logic [1:0] b_rpq;
  logic [2:0] b_ns;

  int checks = 0;
  int fails = 0;

  logic [1:0] m_pq [N];
  logic [7:0] m_as = '0, m_nreq = '0;
  logic m_ov = 1'b0, m_rv = 1'b0;
  logic [2:0] m_os = '0;
  logic [1:0] m_rpq = '0;

  always #2 clk = ~clk;

  ipq_src_ctrl #(.N(N), .PAGE_SHIFT(SH), .LEVEL_MASK(LM)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_pulse(trig), .lvl_in(lvl),
    .store_eoi_en(seoi), .acc_valid(av), .acc_write(aw), .acc_addr(aa),
    .rsp_valid(rv), .rsp_pq(rpq), .ntf_valid(nv), .ntf_ready(nrdy), .ntf_src(ns)
  );

  ipq_src_ctrl #(.N(N), .PAGE_SHIFT(12), .LEVEL_MASK(LM)) u1 (
    .clk(clk), .rst_n(rst_n), .trig_pulse(8'h00), .lvl_in(8'h00),
    .store_eoi_en(1'b1), .acc_valid(b_av), .acc_write(b_aw), .acc_addr(b_aa),
    .rsp_valid(b_rv), .rsp_pq(b_rpq), .ntf_valid(b_nv), .ntf_ready(1'b1), .ntf_src(b_ns)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Operation code from the requirements: 0 none, 1 trig, 2 eoi, 3 get, 4..7 set 00..11
  function automatic int mdec(input logic wr, input logic [15:0] a, input logic en);
    if (a[7:0] != 0) return wr ? 0 : 3;
    if (!a[12]) return wr ? 1 : 3;
    if (wr) return (a[11:8] == 4'h4 && en) ? 2 : 0;
    if (a[11:8] == 4'h0) return 2;
    if (a[11:8] == 4'h8) return 3;
    if (a[11:10] == 2'b11) return 4 + int'(a[9:8]);
    return 3;
  endfunction

  function automatic logic [2:0] mtrig(input logic [1:0] s);
    if (s == 2'b00) return 3'b101;
    if (s == 2'b10) return 3'b110;
    return {s, 1'b0};
  endfunction

  task automatic model_step();
    logic [1:0] np [N];
    logic [7:0] fire, clr;
    logic [2:0] t, pick;
    logic [1:0] s;
    logic f;
    int op, src;
    src = int'(aa[15:13]);
    op = av ? mdec(aw, aa, seoi) : 0;
    if (av && !aw) m_rpq = m_pq[src];
    m_rv = av && !aw;
    fire = '0;
    for (int i = 0; i < N; i++) begin
      s = m_pq[i];
      f = 1'b0;
      if (av && src == i) begin
        if (op == 1) begin
          t = mtrig(s); s = t[2:1]; f = t[0];
        end else if (op == 2) begin
          if (s == 2'b11) begin s = 2'b10; f = 1'b1; end
          else if (s == 2'b10) begin
            if (LM[i] && m_as[i]) f = 1'b1; else s = 2'b00;
          end
        end else if (op >= 4) begin
          s = 2'(op - 4);
        end
      end
      if (LM[i] ? (lvl[i] && !m_as[i]) : trig[i]) begin
        t = mtrig(s); s = t[2:1]; f = f | t[0];
      end
      np[i] = s;
      fire[i] = f;
    end
    clr = '0;
    pick = '0;
    for (int i = N - 1; i >= 0; i--) if (m_nreq[i]) pick = 3'(i);
    if (!m_ov || nrdy) begin
      m_ov = |m_nreq;
      m_os = pick;
      if (|m_nreq) clr[pick] = 1'b1;
    end
    m_nreq = (m_nreq & ~clr) | fire;
    m_as = lvl & LM;
    for (int i = 0; i < N; i++) m_pq[i] = np[i];
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(rv == m_rv, "R4 rsp_valid timing", rv, m_rv);
    if (m_rv) chk(rpq == m_rpq, "R4 old state returned", rpq, m_rpq);
    chk(nv == m_ov, "R9 ntf_valid", nv, m_ov);
    if (m_ov) chk(ns == m_os, "R9 ntf_src", ns, m_os);
  endtask

  task automatic ld(input int s, input int off, input int exp, input string tag);
    av = 1'b1; aw = 1'b0; aa = 16'(s * 8192 + off);
    tick();
    av = 1'b0;
    chk(rv && rpq == 2'(exp), tag, rpq, exp);
  endtask

  task automatic st(input int s, input int off);
    av = 1'b1; aw = 1'b1; aa = 16'(s * 8192 + off);
    tick();
    av = 1'b0; aw = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    trig = m;
    tick();
    trig = '0;
  endtask

  task automatic ld1(input int s, input int off, input int exp, input string tag);
    b_av = 1'b1; b_aw = 1'b0; b_aa = 15'(s * 4096 + off);
    tick();
    b_av = 1'b0;
    chk(b_rv && b_rpq == 2'(exp), tag, b_rpq, exp);
  endtask

  task automatic st1(input int s, input int off);
    b_av = 1'b1; b_aw = 1'b1; b_aa = 15'(s * 4096 + off);
    tick();
    b_av = 1'b0; b_aw = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    for (int i = 0; i < N; i++) m_pq[i] = 2'b00;
    repeat (3) @(negedge clk);
    chk(rv == 1'b0 && nv == 1'b0, "R1 outputs idle in reset", {rv, nv}, 0);
    rst_n = 1'b1;

    // R1: all sources idle after reset
    for (int s = 0; s < N; s++) ld(s, 16'h1800, 0, "R1 reset state idle");

    // R2 / R9: trigger from idle and notification latency
    pulse(8'h02);
    chk(nv == 1'b0, "R9 notification not before second edge", nv, 0);
    tick();
    chk(nv == 1'b1 && ns == 3'd1, "R9 notification after second edge", {nv, ns}, 4'h9);
    ld(1, 16'h1800, 2, "R2 idle to pending");
    pulse(8'h02);
    ld(1, 16'h1800, 3, "R2 pending to queued");
    pulse(8'h02);
    ld(1, 16'h1800, 3, "R2 queued holds");
    chk(nv == 1'b1 && ns == 3'd1, "R9 held while stalled", {nv, ns}, 4'h9);
    nrdy = 1'b1; tick(); nrdy = 1'b0;

    // R3: end of interrupt by load
    ld(1, 16'h1000, 3, "R3 eoi returns queued");
    ld(1, 16'h1800, 2, "R3 queued to pending");
    ld(1, 16'h1000, 2, "R3 eoi returns pending");
    ld(1, 16'h1800, 0, "R3 pending to idle");

    // R5: forced states, and off ignores triggers
    ld(2, 16'h1D00, 0, "R5 set 01 returns old");
    ld(2, 16'h1800, 1, "R5 state is off");
    pulse(8'h04);
    ld(2, 16'h1800, 1, "R2 off ignores trigger");
    ld(2, 16'h1000, 1, "R3 eoi on off");
    ld(2, 16'h1800, 1, "R3 off unchanged by eoi");
    ld(2, 16'h1F00, 1, "R5 set 11");
    ld(2, 16'h1800, 3, "R5 state queued");
    ld(2, 16'h1C00, 3, "R5 set 00");
    ld(2, 16'h1E00, 0, "R5 set 10");
    ld(2, 16'h1800, 2, "R5 state pending");

    // R6: store eoi gated by capability input
    ld(3, 16'h1E00, 0, "R5 set 10 on src3");
    seoi = 1'b0;
    st(3, 16'h1400);
    ld(3, 16'h1800, 2, "R6 store eoi disabled has no effect");
    seoi = 1'b1;
    st(3, 16'h1400);
    ld(3, 16'h1800, 0, "R6 store eoi enabled");

    // R9: lowest number first
    nrdy = 1'b1; repeat (4) tick(); nrdy = 1'b0;
    pulse(8'h28);
    tick();
    chk(nv == 1'b1 && ns == 3'd3, "R9 lowest source first", ns, 3);
    nrdy = 1'b1; tick(); nrdy = 1'b0;
    chk(nv == 1'b1 && ns == 3'd5, "R9 next after handshake", ns, 5);
    nrdy = 1'b1; tick(); nrdy = 1'b0;

    // R7: two-page layout
    st(4, 16'h0000);
    ld(4, 16'h1800, 2, "R7 trigger half store triggers");
    ld(4, 16'h0000, 2, "R7 trigger half load reads");
    ld(4, 16'h1800, 2, "R7 trigger half load no change");
    st(4, 16'h1800);
    ld(4, 16'h1800, 2, "R7 management store ignored");
    ld(4, 16'h1C04, 2, "R7 misaligned load reads");
    ld(4, 16'h1800, 2, "R7 misaligned load no change");

    // R8: level source 6
    pulse(8'h40);
    ld(6, 16'h1800, 0, "R8 pulse ignored on level source");
    lvl[6] = 1'b1; tick();
    ld(6, 16'h1800, 2, "R8 rising level triggers");
    ld(6, 16'h1000, 2, "R8 eoi while asserted");
    ld(6, 16'h1800, 2, "R8 eoi refires asserted level");
    lvl[6] = 1'b0; tick();
    ld(6, 16'h1000, 2, "R8 eoi after deassert");
    ld(6, 16'h1800, 0, "R8 idle after deassert");

    // R10: access first, then hardware trigger
    ld(5, 16'h1F00, 2, "R10 prepare queued");
    trig = 8'h20;
    ld(5, 16'h1000, 3, "R10 eoi with trigger");
    trig = '0;
    ld(5, 16'h1800, 3, "R10 eoi then trigger");
    trig = 8'h20;
    ld(5, 16'h1C00, 3, "R10 set with trigger");
    trig = '0;
    ld(5, 16'h1800, 2, "R10 set then trigger");

    // R7: single-page layout on u1
    st1(3, 15'h0000);
    ld1(3, 15'h0800, 2, "R7 single page store triggers");
    st1(3, 15'h0400);
    ld1(3, 15'h0800, 0, "R7 single page store eoi");

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      int sel;
      int offs;
      trig = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if ($urandom % 16 == 0) lvl[6] = ~lvl[6];
      if ($urandom % 16 == 0) lvl[7] = ~lvl[7];
      if ($urandom % 64 == 0) seoi = ~seoi;
      nrdy = ($urandom % 4) != 0;
      av = ($urandom % 3) == 0;
      aw = $urandom % 2;
      sel = $urandom % 9;
      case (sel)
        0: offs = 16'h0000;
        1: offs = 16'h1000;
        2: offs = 16'h1400;
        3: offs = 16'h1800;
        4: offs = 16'h1C00;
        5: offs = 16'h1D00;
        6: offs = 16'h1E00;
        7: offs = 16'h1F00;
        default: offs = 16'h1004;
      endcase
      aa = 16'(($urandom % 8) * 8192 + offs);
      tick();
    end
    av = 1'b0; aw = 1'b0; trig = '0; nrdy = 1'b1;
    repeat (20) tick();
    chk(nv == 1'b0, "R9 drained", nv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule